// File: doc/BRIEF.md
# Gated Serial Signature Analyzer

The block compresses one serial probe line into a 16-bit residue, in the manner of a bench signature analyzer. A measurement clock line, a start qualifier line and a stop qualifier line arrive as ordinary levels and are oversampled by the system clock. Each line has its own edge-polarity select. An event on the start line opens a measurement window and clears the residue. Every selected edge of the measurement clock inside the window shifts the probe bit into a 16-bit feedback shift register. An event on the stop line closes the window and latches the residue as the result.

The result appears as a raw 16-bit value and as four display characters in a 16-symbol alphabet. A one-cycle done pulse accompanies each new result. An unstable flag reports whether this window's result differs from the previous one. Start and stop may be driven from one net, which gives a window from a falling edge to the next rising edge, or from one falling edge to the next.

The window controller is a three-state machine:
- `S_ARMED`: waiting for a start event.
- `S_OPEN`: window open.
- `S_LATCH`: a one-cycle report state.

Its transitions:
- `S_ARMED` to `S_OPEN` on a start event. `S_ARMED` holds otherwise, and a stop event there is ignored.
- `S_OPEN` to `S_LATCH` on a stop event. `S_OPEN` holds otherwise, and a start event there is ignored.
- `S_LATCH` to `S_OPEN` on a start event. `S_LATCH` to `S_ARMED` otherwise.

Top module: `signature_analyzer`

## Requirements
- R1: After reset the result is 0, the display reads "0000" (32'h30303030), done is 0, unstable is 0, and the controller waits for a start event.
- R2: `clk_rise_i`=1 selects rising edges of `probe_clk_i` as sample edges, and 0 selects falling edges. Edges of the other polarity never shift the residue.
- R3: The start and stop lines each have their own polarity select (`start_rise_i`, `stop_rise_i`: 1 rising, 0 falling). With both lines on one net, start on falling and stop on rising measures the low interval.
- R4: With both lines on one net and both set to falling, a window runs from one falling edge to the next. The rising edges in between neither open nor close a window, and the falling edge after the stop opens a new window.
- R5: A start event clears the residue. Each sample edge then performs r <= {r[14:0], fb}, with fb = probe ^ r[15] ^ r[11] ^ r[8] ^ r[6] (polynomial x^16+x^12+x^9+x^7+1), and the first probe bit is the first bit shifted.
- R6: Sample edges before the start event, after the stop event, or in the same system cycle as the start or the stop event do not change the residue or the result.
- R7: A stop event without an open window produces no done pulse and leaves the result unchanged. A start event while the window is open is ignored and does not clear the residue.
- R8: `done_o` is high for exactly the one system cycle after the cycle in which the stop event is seen, and `sig_o` changes only together with `done_o`.
- R9: `disp_o[31:24]` encodes nibble `sig_o[15:12]` and `disp_o[7:0]` encodes `sig_o[3:0]`, as ASCII. Values 0 to 9 map to '0' to '9', and values 10 to 15 map to 'A', 'C', 'F', 'H', 'P', 'U' in order.
- R10: At each done pulse `unstable_o` becomes 1 if the new result differs from the previous completed result, and 0 otherwise. The first window after reset is never unstable, and the flag holds between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_clk_i | input | 1 | Measurement clock line |
| start_i | input | 1 | Start qualifier line |
| stop_i | input | 1 | Stop qualifier line |
| data_i | input | 1 | Data probe, sampled on the measurement clock edge |
| clk_rise_i | input | 1 | 1: rising sample edge, 0: falling |
| start_rise_i | input | 1 | 1: start on rising edge, 0: falling |
| stop_rise_i | input | 1 | 1: stop on rising edge, 0: falling |
| sig_o | output | 16 | Latched signature |
| disp_o | output | 32 | Four ASCII display characters, most significant first |
| done_o | output | 1 | One-cycle pulse when a new result is latched |
| unstable_o | output | 1 | Set when the result differs from the previous one |

## Verification
A corrupted residue or a mis-tapped feedback appears on `sig_o` and `disp_o` at the done pulse that ends the window, one system cycle after the stop edge, so every window compares a full 16-bit value against a model of the polynomial. A controller stuck in the wrong state shows either as a missing or extra done pulse, or as a result that includes bits from outside the window. A stale copy of the previous result corrupts `unstable_o` on the very next done pulse. The bench therefore repeats identical and differing windows back to back.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_OPEN  = 2'd1,
        S_LATCH = 2'd2
    } win_state_t;

    // Maps a nibble to the analyzer's display alphabet (ASCII).
    function automatic logic [7:0] nibble_glyph(input logic [3:0] n);
        logic [7:0] g;
        case (n)
            4'd10:   g = 8'h41; // A
            4'd11:   g = 8'h43; // C
            4'd12:   g = 8'h46; // F
            4'd13:   g = 8'h48; // H
            4'd14:   g = 8'h50; // P
            4'd15:   g = 8'h55; // U
            default: g = 8'h30 + {4'd0, n};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sa_edge_det.sv
module sa_edge_det #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic [LINES-1:0] line_i,
    input  logic [LINES-1:0] rise_sel_i,
    output logic [LINES-1:0] ev_o
);
    // History of every line; tracks the input during reset as well.
    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= line_i;
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            assign ev_o[g] = rise_sel_i[g] ? (line_i[g] & ~prev_q[g])
                                           : (~line_i[g] & prev_q[g]);
        end
    endgenerate

endmodule

// File: rtl/sa_residue.sv
module sa_residue #(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'h8940
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] res_q;
    logic             fb;

    assign fb    = (^(res_q & TAP_MASK)) ^ bit_i;
    assign res_o = res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (clr_i) begin
            res_q <= '0;
        end else if (shift_i) begin
            res_q <= {res_q[WIDTH-2:0], fb};
        end
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (res_q == '0));

    assert_shift_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=> (res_q[WIDTH-1:1] == $past(res_q[WIDTH-2:0])));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !shift_i) |=> $stable(res_q));

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ev_i,
    input  logic             stop_ev_i,
    input  logic             clk_ev_i,
    input  logic [WIDTH-1:0] residue_i,
    output logic             clr_o,
    output logic             shift_o,
    output logic [WIDTH-1:0] sig_o,
    output logic             done_o,
    output logic             unstable_o
);
    win_state_t       state_q, state_d;
    logic [WIDTH-1:0] sig_q;
    logic             unstable_q;
    logic             have_prev_q;
    logic             latch_now;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARMED: if (start_ev_i) state_d = S_OPEN;
            S_OPEN:  if (stop_ev_i)  state_d = S_LATCH;
            S_LATCH: state_d = start_ev_i ? S_OPEN : S_ARMED;
            default: state_d = S_ARMED;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        clr_o     = 1'b0;
        shift_o   = 1'b0;
        done_o    = 1'b0;
        latch_now = 1'b0;
        unique case (state_q)
            S_ARMED: clr_o = start_ev_i;
            S_OPEN: begin
                shift_o   = clk_ev_i && !stop_ev_i;
                latch_now = stop_ev_i;
            end
            S_LATCH: begin
                done_o = 1'b1;
                clr_o  = start_ev_i;
            end
            default: ;
        endcase
    end

    // Result and stability registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q       <= '0;
            unstable_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (latch_now) begin
            sig_q       <= residue_i;
            unstable_q  <= have_prev_q && (residue_i != sig_q);
            have_prev_q <= 1'b1;
        end
    end

    assign sig_o      = sig_q;
    assign unstable_o = unstable_q;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sig_o));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(unstable_o));

    assert_stray_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && stop_ev_i) |=> !done_o);

    assert_no_shift_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_OPEN) |-> !shift_o);

endmodule

// File: rtl/sa_display.sv
module sa_display
    import sa_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int CHARS = WIDTH / 4
) (
    input  logic [WIDTH-1:0]   sig_i,
    output logic [CHARS*8-1:0] disp_o
);
    generate
        for (genvar c = 0; c < CHARS; c++) begin : g_char
            assign disp_o[c*8 +: 8] = nibble_glyph(sig_i[c*4 +: 4]);
        end
    endgenerate

endmodule

// File: rtl/signature_analyzer.sv
module signature_analyzer #(
    parameter int                SIG_W    = 16,
    parameter logic [SIG_W-1:0]  TAP_MASK = 16'h8940,
    localparam int               CHARS    = SIG_W / 4,
    localparam int               DISP_W   = CHARS * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_clk_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              data_i,
    input  logic              clk_rise_i,
    input  logic              start_rise_i,
    input  logic              stop_rise_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic [DISP_W-1:0] disp_o,
    output logic              done_o,
    output logic              unstable_o
);
    localparam int LINES = 3;

    logic [LINES-1:0] ev;
    logic             clr, shift;
    logic [SIG_W-1:0] residue;

    sa_edge_det #(.LINES(LINES)) u_edges (
        .clk        (clk),
        .line_i     ({stop_i, start_i, probe_clk_i}),
        .rise_sel_i ({stop_rise_i, start_rise_i, clk_rise_i}),
        .ev_o       (ev)
    );

    sa_residue #(.WIDTH(SIG_W), .TAP_MASK(TAP_MASK)) u_residue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .shift_i (shift),
        .bit_i   (data_i),
        .res_o   (residue)
    );

    sa_ctrl #(.WIDTH(SIG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ev_i (ev[1]),
        .stop_ev_i  (ev[2]),
        .clk_ev_i   (ev[0]),
        .residue_i  (residue),
        .clr_o      (clr),
        .shift_o    (shift),
        .sig_o      (sig_o),
        .done_o     (done_o),
        .unstable_o (unstable_o)
    );

    sa_display #(.WIDTH(SIG_W)) u_disp (
        .sig_i  (sig_o),
        .disp_o (disp_o)
    );

    assert_first_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && sig_o == $past(sig_o)) |-> !unstable_o);

endmodule

// File: tb/test_signature_analyzer.sv
`timescale 1ns/1ps
module test_signature_analyzer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        probe_clk = 1'b0, start_ln = 1'b0, stop_ln = 1'b0, data = 1'b0;
    logic        clk_rise = 1'b1, start_rise = 1'b1, stop_rise = 1'b1;
    logic        tie = 1'b0;
    logic [15:0] sig;
    logic [31:0] disp;
    logic        done, unstable;

    int checks = 0;
    int errors = 0;
    logic        finished = 1'b0;

    logic [15:0] prev_sig = '0;
    logic        have_prev = 1'b0;

    always #2 clk = ~clk;

    signature_analyzer i_signature_analyzer (
        .clk          (clk),
        .rst_n        (rst_n),
        .probe_clk_i  (probe_clk),
        .start_i      (start_ln),
        .stop_i       (tie ? start_ln : stop_ln),
        .data_i       (data),
        .clk_rise_i   (clk_rise),
        .start_rise_i (start_rise),
        .stop_rise_i  (stop_rise),
        .sig_o        (sig),
        .disp_o       (disp),
        .done_o       (done),
        .unstable_o   (unstable)
    );

    // {length, pattern}; bit i of the pattern is the i-th probe bit
    localparam logic [20:0] VEC [0:7] = '{
        {5'd16, 16'h0000}, {5'd16, 16'h0000}, {5'd16, 16'hFFFF}, {5'd16, 16'hA5C3},
        {5'd1,  16'h0001}, {5'd0,  16'h0000}, {5'd8,  16'h00FF}, {5'd16, 16'h1234}
    };

    function automatic logic [15:0] model_sig(input logic [15:0] pat, input int len);
        logic [15:0] r = '0;
        for (int i = 0; i < len; i++) begin
            logic fb;
            fb = pat[i] ^ r[15] ^ r[11] ^ r[8] ^ r[6];
            r = {r[14:0], fb};
        end
        return r;
    endfunction

    function automatic logic [7:0] model_glyph(input logic [3:0] n);
        logic [7:0] lut [0:5] = '{8'h41, 8'h43, 8'h46, 8'h48, 8'h50, 8'h55};
        if (n < 4'd10) return 8'h30 + {4'd0, n};
        return lut[n - 4'd10];
    endfunction

    function automatic logic [31:0] model_disp(input logic [15:0] s);
        return {model_glyph(s[15:12]), model_glyph(s[11:8]),
                model_glyph(s[7:4]), model_glyph(s[3:0])};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin data = b; probe_clk = clk_rise; end
        @(negedge clk) begin probe_clk = ~clk_rise; data = ~b; end
    endtask

    task automatic fire_start();
        @(negedge clk) start_ln = start_rise;
        @(negedge clk) start_ln = ~start_rise;
    endtask

    // At the cycle after the stop event: compare result, display, flag
    task automatic check_result(input string req, input logic [15:0] exp);
        logic exp_unst;
        exp_unst = have_prev && (exp != prev_sig);
        check("R8 done pulse", {31'd0, done}, 32'd1);
        check(req, {16'd0, sig}, {16'd0, exp});
        check("R9 display", disp, model_disp(exp));
        check("R10 unstable", {31'd0, unstable}, {31'd0, exp_unst});
        prev_sig  = exp;
        have_prev = 1'b1;
    endtask

    task automatic run_window(input logic [15:0] pat, input int len, input string req);
        fire_start();
        for (int i = 0; i < len; i++) send_bit(pat[i]);
        @(negedge clk) stop_ln = stop_rise;
        @(negedge clk);
        check_result(req, model_sig(pat, len));
        stop_ln = ~stop_rise;
        @(negedge clk);
        check("R8 done low", {31'd0, done}, 32'd0);
    endtask

    initial begin
        logic [15:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sig", {16'd0, sig}, 32'd0);
        check("R1 disp", disp, 32'h30303030);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 unstable", {31'd0, unstable}, 32'd0);

        // Table walk, default polarities (all rising)
        for (int v = 0; v < 8; v++)
            run_window(VEC[v][15:0], int'(VEC[v][20:16]), "R5 table signature");

        // R2: falling sample edges
        @(negedge clk) begin clk_rise = 1'b0; probe_clk = 1'b1; end
        run_window(16'h6C3B, 16, "R2 falling clock");
        run_window(16'h6C3B, 16, "R2 falling clock repeat");
        @(negedge clk) begin clk_rise = 1'b1; probe_clk = 1'b0; end

        // R6: edges before start and after stop are ignored
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        run_window(16'h0005, 3, "R6 pre-start edges ignored");
        held = sig;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check("R6 post-stop sig", {16'd0, sig}, {16'd0, held});
        check("R6 post-stop done", {31'd0, done}, 32'd0);

        // R6: sample edge coinciding with start is ignored
        @(negedge clk) begin start_ln = 1'b1; probe_clk = 1'b1; data = 1'b1; end
        @(negedge clk) begin start_ln = 1'b0; probe_clk = 1'b0; end
        @(negedge clk) stop_ln = 1'b1;
        @(negedge clk);
        check_result("R6 coincident start edge", 16'h0000);
        stop_ln = 1'b0;

        // R6: sample edge coinciding with stop is ignored
        fire_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk) begin stop_ln = 1'b1; probe_clk = 1'b1; data = 1'b1; end
        @(negedge clk);
        check_result("R6 coincident stop edge", model_sig(16'h0005, 3));
        stop_ln = 1'b0; probe_clk = 1'b0;

        // R7: stray stop
        held = sig;
        @(negedge clk) stop_ln = 1'b1;
        @(negedge clk);
        check("R7 stray stop done", {31'd0, done}, 32'd0);
        stop_ln = 1'b0;
        @(negedge clk);
        check("R7 stray stop sig", {16'd0, sig}, {16'd0, held});

        // R7: second start inside the window does not clear
        fire_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        fire_start();
        send_bit(1'b1); send_bit(1'b0);
        @(negedge clk) stop_ln = 1'b1;
        @(negedge clk);
        check_result("R7 restart ignored", model_sig(16'h000B, 5));
        stop_ln = 1'b0;

        // R3: one net, start falling, stop rising
        @(negedge clk) begin tie = 1'b1; start_rise = 1'b0; stop_rise = 1'b1; start_ln = 1'b1; end
        repeat (2) @(negedge clk);
        @(negedge clk) start_ln = 1'b0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        @(negedge clk) start_ln = 1'b1;
        @(negedge clk);
        check_result("R3 shared net low interval", model_sig(16'h000E, 4));

        // R4: one net, both falling; two consecutive windows
        @(negedge clk) stop_rise = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk) start_ln = 1'b0;
        @(negedge clk) start_ln = 1'b1;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk) start_ln = 1'b0;
        @(negedge clk);
        check_result("R4 falling to falling", model_sig(16'h0009, 4));
        start_ln = 1'b1;
        @(negedge clk) start_ln = 1'b0;
        @(negedge clk) start_ln = 1'b1;
        send_bit(1'b1); send_bit(1'b1);
        @(negedge clk) start_ln = 1'b0;
        @(negedge clk);
        check_result("R4 next window opens", model_sig(16'h0003, 2));
        start_ln = 1'b1;

        // R10 / R1: reset clears history; first window is clean
        @(negedge clk) begin tie = 1'b0; start_rise = 1'b1; stop_rise = 1'b1;
                             start_ln = 1'b0; stop_ln = 1'b0; rst_n = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 re-reset sig", {16'd0, sig}, 32'd0);
        check("R1 re-reset unstable", {31'd0, unstable}, 32'd0);
        have_prev = 1'b0;
        run_window(16'hBEEF, 16, "R10 first window after reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule